// File: doc/BRIEF.md
# Static Memory Bus Timing Sequencer

This block runs single read and write transfers on an asynchronous external memory bus that serves six devices, one per chip select. A host issues a transfer with a one-cycle request strobe and waits for a one-cycle ready pulse. The block then produces the chip selects, output enable, write enable, address-latch strobe, address and data-direction signals. Each chip select has its own timing. Every strobe width, hold, recovery gap and page-entry latency comes from a per-select timing word and a per-select mode word, both written through a small configuration port.

Recovery gaps are inserted only where a device that was just read could still be driving the data bus. That means a read followed by an access to another select, or a read followed by a write to the same select. The page-entry latency is charged only when a transfer enters a page that differs from the previous one. A select can also be put into an address-latch read mode. In that mode the address is presented with a one-cycle latch strobe ahead of output enable, and it can optionally be held for one extra cycle.

Top module: `smem_seq`

## Requirements
- R1: A write on the configuration port picks the select with cfg_addr[2:0]. cfg_addr[3]=0 writes the timing word and cfg_addr[3]=1 writes the mode word. Timing word fields: [31:28] recovery, [27:24] write hold, [23:16] write page latency, [15:8] read page latency, [7:4] write wait, [3:0] read wait. Mode word fields: [0] select enable, [1] address-latch read mode, [2] address hold, [5:4] latch-to-OE distance, [11:8] read hold. The new value applies to the next request.
- R2: A plain read holds mem_oe_n low for (read wait + 1) consecutive cycles with its chip select low. For the whole time its select is low, mem_addr carries the request address; otherwise mem_addr is zero.
- R3: A write holds mem_we_n low for (write wait + 1) cycles. After that the select stays low with mem_we_n high for write-hold cycles (0 to 15). mem_dout_en is high on exactly the select-low cycles of a write, and during those cycles mem_dout carries the request data.
- R4: From the cycle a request is accepted, two idle bus cycles pass before any select goes low. If the previous accepted transfer was a read, and the new one is a write or targets another select, (recovery + 1) further idle cycles are added, using the recovery field of the select read last.
- R5: Before the strobe, the select is low with no strobe for the read or write page latency (0 to 255 cycles). This applies only on the first transfer after reset, on a select change, or when address bits above bit 4 differ from the previous transfer. Otherwise the count is zero.
- R6: A read to a select in address-latch mode drives mem_adv_n low for exactly one cycle. mem_oe_n goes low N cycles later, where N is the latch-to-OE distance (0 gives the same cycle). The time from select assertion to OE equals max(read hold, N) plus any page latency. mem_addr is zero except in the latch window.
- R7: In address-latch mode with the address-hold bit set, mem_addr keeps the address for one cycle after mem_adv_n rises. With the bit clear, the address is present only in the latch cycle.
- R8: A request to a select whose enable bit is clear, or to select 6 or 7, leaves every bus output idle. It still gets a ready pulse with req_rdata zero, and it leaves the recovery and page record unchanged.
- R9: At most one select is low at any time. mem_oe_n and mem_we_n are never low together. OE low implies a select low, and mem_dout_en is never high while OE is low.
- R10: req_ready pulses for one cycle, in the first idle cycle after a transfer. For a read, req_rdata equals mem_din as seen in the last OE-low cycle. Requests are accepted only while the sequencer is idle.
- R11: A synchronous active-high reset drives all selects, mem_oe_n, mem_we_n and mem_adv_n high, mem_dout_en and req_ready low. It clears all timing and mode words, which disables every select, and it empties the page record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | [3] word kind (timing/mode), [2:0] select index |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Transfer request, accepted while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Target chip select |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data returned with ready |
| mem_cs_n | output | 6 | Chip selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address-latch strobe, active low |
| mem_addr | output | 16 | Memory address |
| mem_dout | output | 16 | Write data toward memory |
| mem_dout_en | output | 1 | Data output enable (drive when high) |
| mem_din | input | 16 | Read data from memory |

## Verification
Three input patterns drive the sequence. Back-to-back reads in one page, reads followed by writes on the same select, and hops between selects separate the recovery decision from the page-latency decision, since each pattern expects a different idle-gap and lead count. Latch-mode reads are tried with a long read hold and a nonzero latch distance, and then with both at zero, which tells the latch placement apart from the select-to-OE count and the held address from the single-cycle one. Rejected requests are followed by a transfer whose lead count would change if the rejection had touched the page record. Extreme field values (255-cycle latency, 16-cycle wait) confirm that the counters span the full range.

// File: rtl/smem_pkg.sv
package smem_pkg;

  // Per-select timing word; packed order matches the register bit layout.
  typedef struct packed {
    logic [3:0] recov;
    logic [3:0] wr_hold;
    logic [7:0] wr_lat;
    logic [7:0] rd_lat;
    logic [3:0] wr_wait;
    logic [3:0] rd_wait;
  } tword_t;

  // Per-select mode word (low 12 bits of the configuration data).
  typedef struct packed {
    logic [3:0] rd_hold;
    logic [1:0] rsv_hi;
    logic [1:0] adv_oe;
    logic       rsv_lo;
    logic       addr_hold;
    logic       latch_mode;
    logic       enable;
  } mword_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_RECOV, ST_LAT, ST_PRE, ST_ACC, ST_HOLD, ST_DONE
  } seq_st_e;

endpackage

// File: rtl/smem_cfg_regs.sv
module smem_cfg_regs
  import smem_pkg::*;
#(
  parameter int NUM_CS = 6,
  localparam int CSW = $clog2(NUM_CS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [CSW:0]   cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output tword_t         tw [NUM_CS],
  output mword_t         mw [NUM_CS]
);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_wdata[31:12];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) begin
        tw[g] <= '0;
        mw[g] <= '0;
      end else if (cfg_we && cfg_addr[CSW-1:0] == CSW'(g)) begin
        if (cfg_addr[CSW]) mw[g] <= mword_t'(cfg_wdata[11:0]);
        else               tw[g] <= tword_t'(cfg_wdata);
      end
    end
  end

endmodule

// File: rtl/smem_fsm.sv
module smem_fsm
  import smem_pkg::*;
#(
  parameter int NUM_CS   = 6,
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int PAGE_LSB = 5,
  localparam int CSW = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst,
  input  tword_t            tw [NUM_CS],
  input  mword_t            mw [NUM_CS],
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic [DW-1:0]     req_rdata,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_adv_n,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_dout,
  output logic              mem_dout_en,
  input  logic [DW-1:0]     mem_din
);

  localparam int PW = AW - PAGE_LSB;
  localparam int CW = 8;
  localparam int LW = CW + 1;
  typedef logic [LW-1:0] len_t;

  seq_st_e         st, st_nx;
  logic [CW-1:0]   cnt, cnt_nx;

  // Accepted operation
  logic            op_wr, op_ok, op_rec, op_newpg;
  logic [CSW-1:0]  op_cs;
  logic [AW-1:0]   op_addr;
  logic [DW-1:0]   op_wdata;

  // Record of the last valid transfer
  logic [CSW-1:0]  last_cs;
  logic [PW-1:0]   last_page;
  logic            page_vld, last_rd;

  logic            in_range;
  logic [CSW-1:0]  req_idx;
  assign in_range = (int'(req_cs) < NUM_CS);
  assign req_idx  = in_range ? req_cs : '0;

  tword_t ctw, ltw;
  mword_t cmw;
  assign ctw = tw[op_cs];
  assign cmw = mw[op_cs];
  assign ltw = tw[last_cs];

  logic latch_rd;
  assign latch_rd = cmw.latch_mode && !op_wr;

  len_t lat_len, pre_len, acc_len, hold_len, rec_len, ld_len, ld_m1, acc_m1;
  always_comb begin
    lat_len = '0;
    if (op_newpg) lat_len = LW'(op_wr ? ctw.wr_lat : ctw.rd_lat);
    pre_len = '0;
    if (latch_rd)
      pre_len = (cmw.rd_hold >= {2'b00, cmw.adv_oe}) ? LW'(cmw.rd_hold) : LW'(cmw.adv_oe);
    acc_len  = LW'(op_wr ? ctw.wr_wait : ctw.rd_wait) + LW'(1);
    hold_len = op_wr ? LW'(ctw.wr_hold) : '0;
    rec_len  = LW'(ltw.recov) + LW'(1);
    acc_m1   = acc_len - LW'(1);
  end

  seq_st_e after_rec, after_lat, after_acc;
  assign after_lat = (pre_len != '0) ? ST_PRE : ST_ACC;
  assign after_rec = (lat_len != '0) ? ST_LAT : after_lat;
  assign after_acc = (hold_len != '0) ? ST_HOLD : ST_DONE;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (req_valid) st_nx = ST_START;
      ST_START: st_nx = !op_ok ? ST_DONE : (op_rec ? ST_RECOV : after_rec);
      ST_RECOV: if (cnt == '0) st_nx = after_rec;
      ST_LAT:   if (cnt == '0) st_nx = after_lat;
      ST_PRE:   if (cnt == '0) st_nx = ST_ACC;
      ST_ACC:   if (cnt == '0) st_nx = after_acc;
      ST_HOLD:  if (cnt == '0) st_nx = ST_DONE;
      ST_DONE:  st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
    unique case (st_nx)
      ST_RECOV: ld_len = rec_len;
      ST_LAT:   ld_len = lat_len;
      ST_PRE:   ld_len = pre_len;
      ST_ACC:   ld_len = acc_len;
      ST_HOLD:  ld_len = hold_len;
      default:  ld_len = LW'(1);
    endcase
    ld_m1 = ld_len - LW'(1);
    if (st_nx != st)    cnt_nx = ld_m1[CW-1:0];
    else if (cnt != '0) cnt_nx = cnt - CW'(1);
    else                cnt_nx = '0;
  end

  // Bus decode of the present state; registered below.
  logic cs_act, adv_now;
  logic [AW-1:0] addr_nx;
  always_comb begin
    cs_act  = (st == ST_LAT) || (st == ST_PRE) || (st == ST_ACC) || (st == ST_HOLD);
    adv_now = latch_rd &&
              ((st == ST_PRE && cmw.adv_oe != 2'd0 && cnt == CW'(cmw.adv_oe) - CW'(1)) ||
               (st == ST_ACC && cmw.adv_oe == 2'd0 && cnt == acc_m1[CW-1:0]));
    if (latch_rd)
      addr_nx = (adv_now || (cmw.addr_hold && !mem_adv_n)) ? op_addr : '0;
    else
      addr_nx = cs_act ? op_addr : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      op_wr       <= 1'b0;
      op_ok       <= 1'b0;
      op_rec      <= 1'b0;
      op_newpg    <= 1'b0;
      op_cs       <= '0;
      op_addr     <= '0;
      op_wdata    <= '0;
      last_cs     <= '0;
      last_page   <= '0;
      page_vld    <= 1'b0;
      last_rd     <= 1'b0;
      req_ready   <= 1'b0;
      req_rdata   <= '0;
      mem_cs_n    <= '1;
      mem_oe_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_adv_n   <= 1'b1;
      mem_addr    <= '0;
      mem_dout    <= '0;
      mem_dout_en <= 1'b0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
      if (st == ST_IDLE && req_valid) begin
        op_wr    <= req_write;
        op_cs    <= req_idx;
        op_addr  <= req_addr;
        op_wdata <= req_wdata;
        op_ok    <= in_range && mw[req_idx].enable;
        op_rec   <= last_rd && (req_idx != last_cs || req_write);
        op_newpg <= !page_vld || req_idx != last_cs ||
                    req_addr[AW-1:PAGE_LSB] != last_page;
      end
      if (st == ST_DONE) begin
        if (!op_ok)      req_rdata <= '0;
        else if (!op_wr) req_rdata <= mem_din;
        if (op_ok) begin
          last_cs   <= op_cs;
          last_page <= op_addr[AW-1:PAGE_LSB];
          page_vld  <= 1'b1;
          last_rd   <= !op_wr;
        end
      end
      req_ready   <= (st == ST_DONE);
      mem_cs_n    <= cs_act ? ~(NUM_CS'(1) << op_cs) : '1;
      mem_oe_n    <= !(st == ST_ACC && !op_wr);
      mem_we_n    <= !(st == ST_ACC && op_wr);
      mem_adv_n   <= !adv_now;
      mem_addr    <= addr_nx;
      mem_dout    <= op_wdata;
      mem_dout_en <= op_wr && ((st == ST_LAT) || (st == ST_ACC) || (st == ST_HOLD));
    end
  end

endmodule

// File: rtl/smem_seq.sv
module smem_seq
  import smem_pkg::*;
#(
  parameter int NUM_CS   = 6,
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int PAGE_LSB = 5,
  localparam int CSW = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CSW:0]      cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic [DW-1:0]     req_rdata,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_adv_n,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_dout,
  output logic              mem_dout_en,
  input  logic [DW-1:0]     mem_din
);

  tword_t tw [NUM_CS];
  mword_t mw [NUM_CS];

  smem_cfg_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tw(tw), .mw(mw)
  );

  smem_fsm #(.NUM_CS(NUM_CS), .AW(AW), .DW(DW), .PAGE_LSB(PAGE_LSB)) u_fsm (
    .clk(clk), .rst(rst), .tw(tw), .mw(mw),
    .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_adv_n(mem_adv_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

endmodule

// File: rtl/smem_seq_chk.sv
module smem_seq_chk #(
  parameter int NUM_CS = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CS-1:0] mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_adv_n,
  input logic              mem_dout_en,
  input logic              req_ready
);

  assert_cs_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));

  assert_no_dual_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  assert_oe_with_cs_R9: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_cs_n != '1));

  assert_dout_en_write_R3: assert property (@(posedge clk) disable iff (rst)
    mem_dout_en |-> (mem_oe_n && mem_cs_n != '1));

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  assert_adv_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_adv_n |=> mem_adv_n);

  assert_adv_with_cs_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_adv_n |-> (mem_cs_n != '1));

endmodule

bind smem_seq smem_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst(rst), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n), .mem_dout_en(mem_dout_en),
  .req_ready(req_ready)
);

// File: tb/smem_seq_bench.sv
module smem_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_cs = '0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready;
  logic [15:0] req_rdata;
  logic [5:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n, mem_adv_n, mem_dout_en;
  logic [15:0] mem_addr, mem_dout, mem_din;
  logic [15:0] cur_addr = '0;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  assign mem_din = !mem_oe_n ? (cur_addr ^ 16'h5A5A) : 16'hDEAD;

  smem_seq u_smem_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_rdata(req_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Issues one request and measures the bus until ready.
  task automatic xfer(input bit wr, input logic [2:0] cs, input logic [15:0] addr,
                      input logic [15:0] wd,
                      output int pre, output int lead, output int strobe, output int tail,
                      output int adv_idx, output int acnt, output int bad_addr,
                      output int bad_den, output int bad_wd, output int rdata);
    int phase = 0;
    int csi = 0;
    bit done = 0;
    pre = 0; lead = 0; strobe = 0; tail = 0; adv_idx = 255; acnt = 0;
    bad_addr = 0; bad_den = 0; bad_wd = 0; rdata = -1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cs = cs; req_addr = addr; req_wdata = wd;
    cur_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (req_ready) begin
        done = 1;
        rdata = int'(req_rdata);
        break;
      end
      if (mem_cs_n == 6'h3F) begin
        if (phase == 0) pre++;
        if (mem_addr != 16'h0) bad_addr++;
      end else begin
        if (!mem_oe_n || !mem_we_n) begin strobe++; phase = 2; end
        else if (phase <= 1) begin lead++; phase = 1; end
        else begin tail++; phase = 3; end
        if (!mem_adv_n) adv_idx = csi;
        csi++;
      end
      if (mem_addr == addr && mem_addr != 16'h0) acnt++;
      if (mem_dout_en != (wr && mem_cs_n != 6'h3F)) bad_den++;
      if (mem_dout_en && mem_dout != wd) bad_wd++;
      @(negedge clk);
    end
    if (!done) check("R10 ready timeout", 0, 1);
  endtask

  // {wr, cs, addr, pre, lead, strobe, tail, adv_idx, latch_addr_cycles}
  localparam logic [67:0] VEC [10] = '{
    {1'b0, 3'd0, 16'h0040, 8'd2, 8'd5,   8'd3,  8'd0, 8'd255, 8'd0},
    {1'b0, 3'd0, 16'h0048, 8'd2, 8'd0,   8'd3,  8'd0, 8'd255, 8'd0},
    {1'b1, 3'd0, 16'h0050, 8'd5, 8'd0,   8'd2,  8'd3, 8'd255, 8'd0},
    {1'b1, 3'd0, 16'h0100, 8'd2, 8'd4,   8'd2,  8'd3, 8'd255, 8'd0},
    {1'b0, 3'd1, 16'h0100, 8'd2, 8'd2,   8'd1,  8'd0, 8'd255, 8'd0},
    {1'b1, 3'd0, 16'h0100, 8'd3, 8'd4,   8'd2,  8'd3, 8'd255, 8'd0},
    {1'b0, 3'd2, 16'h0123, 8'd2, 8'd4,   8'd4,  8'd0, 8'd2,   8'd2},
    {1'b0, 3'd4, 16'h0200, 8'd4, 8'd0,   8'd2,  8'd0, 8'd0,   8'd1},
    {1'b0, 3'd5, 16'h0000, 8'd3, 8'd255, 8'd16, 8'd0, 8'd255, 8'd0},
    {1'b1, 3'd1, 16'h0004, 8'd3, 8'd0,   8'd1,  8'd0, 8'd255, 8'd0}
  };

  initial begin
    #(4 * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int pre, lead, strobe, tail, adv, acnt, bad_addr, bad_den, bad_wd, rdata;
    repeat (3) @(negedge clk);
    // R11: idle state under reset
    check("R11 cs_n idle", int'(mem_cs_n), 63);
    check("R11 strobes idle", int'({mem_oe_n, mem_we_n, mem_adv_n}), 7);
    check("R11 dout_en/ready low", int'({mem_dout_en, req_ready}), 0);
    rst = 1'b0;

    // R1: program timing words (kind 0) and mode words (kind 1)
    cfg_write(4'h0, 32'h2304_0512);
    cfg_write(4'h1, 32'h0000_0200);
    cfg_write(4'h2, 32'h1100_0003);
    cfg_write(4'h3, 32'h0000_0000);
    cfg_write(4'h4, 32'h0000_0001);
    cfg_write(4'h5, 32'h0000_FF0F);
    cfg_write(4'h8, 32'h0000_0001);
    cfg_write(4'h9, 32'h0000_0001);
    cfg_write(4'hA, 32'h0000_0427);
    cfg_write(4'hB, 32'h0000_0000);
    cfg_write(4'hC, 32'h0000_0003);
    cfg_write(4'hD, 32'h0000_0001);

    foreach (VEC[k]) begin
      logic [67:0] v;
      v = VEC[k];
      xfer(v[67], v[66:64], v[63:48], 16'hC0DE ^ v[63:48],
           pre, lead, strobe, tail, adv, acnt, bad_addr, bad_den, bad_wd, rdata);
      check($sformatf("R4 row%0d idle gap", k), pre, int'(v[47:40]));
      check($sformatf("R5 R1 row%0d lead", k), lead, int'(v[39:32]));
      check($sformatf("R2 R3 row%0d strobe", k), strobe, int'(v[31:24]));
      check($sformatf("R3 row%0d hold", k), tail, int'(v[23:16]));
      check($sformatf("R9 row%0d dout_en", k), bad_den, 0);
      if (v[7:0] != 8'd0) begin
        check($sformatf("R6 row%0d latch position", k), adv, int'(v[15:8]));
        check($sformatf("R7 row%0d address cycles", k), acnt, int'(v[7:0]));
      end else begin
        check($sformatf("R2 row%0d address", k), bad_addr, 0);
      end
      if (v[67]) check($sformatf("R3 row%0d write data", k), bad_wd, 0);
      else check($sformatf("R10 row%0d read data", k), rdata, int'(v[63:48] ^ 16'h5A5A));
    end

    // R8: disabled select 3 and out-of-range select 7
    xfer(1'b0, 3'd3, 16'h0033, 16'h0,
         pre, lead, strobe, tail, adv, acnt, bad_addr, bad_den, bad_wd, rdata);
    check("R8 disabled no bus cycle", lead + strobe + tail, 0);
    check("R8 disabled rdata zero", rdata, 0);
    xfer(1'b0, 3'd7, 16'h0077, 16'h0,
         pre, lead, strobe, tail, adv, acnt, bad_addr, bad_den, bad_wd, rdata);
    check("R8 out-of-range no bus cycle", lead + strobe + tail, 0);
    check("R8 out-of-range rdata zero", rdata, 0);
    // Record untouched: same select and page as the last write, no recovery, no latency
    xfer(1'b0, 3'd1, 16'h0008, 16'h0,
         pre, lead, strobe, tail, adv, acnt, bad_addr, bad_den, bad_wd, rdata);
    check("R8 R4 record kept gap", pre, 2);
    check("R8 R5 record kept lead", lead, 0);
    check("R10 data after reject", rdata, int'(16'h0008 ^ 16'h5A5A));

    // R1: reprogram select 1 read wait to 5 (6 cycles)
    cfg_write(4'h1, 32'h0000_0205);
    xfer(1'b0, 3'd1, 16'h0010, 16'h0,
         pre, lead, strobe, tail, adv, acnt, bad_addr, bad_den, bad_wd, rdata);
    check("R1 new read wait", strobe, 6);
    check("R5 same page lead", lead, 0);

    // R11: reset clears configuration, so select 0 is now disabled
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 ready low in reset", int'(req_ready), 0);
    rst = 1'b0;
    xfer(1'b0, 3'd0, 16'h0040, 16'h0,
         pre, lead, strobe, tail, adv, acnt, bad_addr, bad_den, bad_wd, rdata);
    check("R11 config cleared", lead + strobe + tail, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule